// File: doc/BRIEF.md
# Scan Channel Unknown-Value Masking Unit

This unit sits between the tail flops of a set of internal scan channels and an XOR-based response compactor. During unload shifting it forces the output of a chosen channel to logic 0, so an unknown value captured in that channel cannot reach the compactor. A forced 0 is neutral for XOR compaction. Which channels are masked is held in per-channel mask bits. These bits are loaded serially once per test pattern through a small group of scan inputs. Each scan input feeds its own shift-register segment, and each segment covers a contiguous group of channels.

The unit has two runtime modes. In single mode each channel has one mask bit, and that bit is applied under one per-cycle enable. In dual mode each channel has two mask bits, each paired with its own per-cycle enable. The test generator can then suppress unknowns on different cycle sets without reloading. A global mask-off input makes every channel transparent, whatever mask bits are stored.

Top module: `xmask_unit`

## Requirements
- R1: After reset every mask bit is 0, so all channel outputs equal their inputs under any enable setting.
- R2: While `mask_load` is 1, each segment shifts by one on the clock edge. `mask_sin[s]` enters the first-mask bit of local position 0 of segment s, and local position i moves to i+1. Segment s covers channels s*SEG_LEN to s*SEG_LEN+SEG_LEN-1, with local position i being channel s*SEG_LEN+i.
- R3: In dual mode (`dual_mode`=1) the shift continues into the second-mask chain. The first-mask bit at local position SEG_LEN-1 moves into second-mask position 0, and second-mask position i moves to i+1. In single mode the second-mask bits hold during a load.
- R4: While `mask_load` is 0, all mask bits keep their values, whatever `mask_sin` carries.
- R5: In single mode a channel is masked in a cycle when `apply_en0` is 1 and its first-mask bit is 1. `apply_en1` has no effect.
- R6: In dual mode a channel is masked when (`apply_en0` AND first-mask bit) OR (`apply_en1` AND second-mask bit).
- R7: A masked channel outputs 0. An unmasked channel outputs its input unchanged, in the same cycle, with no register on the path.
- R8: When `mask_off` is 1, every channel output equals its input, regardless of the stored mask bits and enables.
- R9: In a cycle where `mask_load` is 1, gating uses the mask bits held before that clock edge. Newly shifted bits take effect only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan shift clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dual_mode | input | 1 | 1 = two mask bits per channel, 0 = one |
| mask_off | input | 1 | 1 = all channels pass through unmasked |
| mask_load | input | 1 | 1 = shift the mask segments this cycle |
| mask_sin | input | MASK_IN_W | Serial mask data, one bit per segment |
| apply_en0 | input | 1 | Per-cycle enable for the first mask bits |
| apply_en1 | input | 1 | Per-cycle enable for the second mask bits (dual mode) |
| chan_in | input | NUM_CH | Scan channel tail values |
| chan_out | output | NUM_CH | Gated values towards the compactor |

## Verification
Mask loading and per-cycle gating can happen in the same cycle: shifting new mask bits in while the enables and channel data are active. The bench provokes this on purpose. Random runs keep enables, marker-valued channel data and `mask_off` toggling during load cycles. Each such cycle is judged before the clock edge against a reference mask image that is updated only at the edge. A design that lets freshly shifted bits gate the current cycle therefore shows a mismatch on the affected channels.

// File: rtl/xmask_pkg.sv
package xmask_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DUAL   = 1'b1
  } mask_mode_e;
endpackage

// File: rtl/xmask_rst_sync.sv
module xmask_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/xmask_seg.sv
module xmask_seg
  import xmask_pkg::*;
#(
  parameter int SEG_LEN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  mask_mode_e         mode_i,
  input  logic               din_i,
  output logic [SEG_LEN-1:0] m0_o,
  output logic [SEG_LEN-1:0] m1_o
);
  logic [SEG_LEN-1:0] m0_q, m0_nxt;
  logic [SEG_LEN-1:0] m1_q, m1_nxt;
  logic               m0_en, m1_en;

  assign m0_en = load_i;
  assign m1_en = load_i && (mode_i == MODE_DUAL);

  always_comb begin
    m0_nxt[0] = din_i;
    m1_nxt[0] = m0_q[SEG_LEN-1];
    for (int i = 1; i < SEG_LEN; i++) begin
      m0_nxt[i] = m0_q[i-1];
      m1_nxt[i] = m1_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m0_q <= '0;
      m1_q <= '0;
    end else begin
      if (m0_en) m0_q <= m0_nxt;
      if (m1_en) m1_q <= m1_nxt;
    end
  end

  assign m0_o = m0_q;
  assign m1_o = m1_q;

  // R2
  load_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> m0_q[0] == $past(din_i));
  // R3
  dual_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && mode_i == MODE_DUAL) |=> m1_q[0] == $past(m0_q[SEG_LEN-1]));
  // R3
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && mode_i == MODE_SINGLE) |=> $stable(m1_q));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(m0_q) && $stable(m1_q)));
endmodule

// File: rtl/xmask_gate.sv
module xmask_gate
  import xmask_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0] chan_i,
  input  logic [NUM_CH-1:0] m0_i,
  input  logic [NUM_CH-1:0] m1_i,
  input  logic              en0_i,
  input  logic              en1_i,
  input  mask_mode_e        mode_i,
  input  logic              off_i,
  output logic [NUM_CH-1:0] chan_o
);
  logic en1_live;
  assign en1_live = en1_i && (mode_i == MODE_DUAL);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic kill;
    assign kill      = !off_i && ((en0_i && m0_i[c]) || (en1_live && m1_i[c]));
    assign chan_o[c] = chan_i[c] && !kill;
  end

  always_comb begin
    // R7
    zero_only_chk: assert ((chan_o & ~chan_i) == '0);
    // R8
    if (off_i) begin
      off_pass_chk: assert (chan_o == chan_i);
    end
  end
endmodule

// File: rtl/xmask_unit.sv
module xmask_unit
  import xmask_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int MASK_IN_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dual_mode,
  input  logic                 mask_off,
  input  logic                 mask_load,
  input  logic [MASK_IN_W-1:0] mask_sin,
  input  logic                 apply_en0,
  input  logic                 apply_en1,
  input  logic [NUM_CH-1:0]    chan_in,
  output logic [NUM_CH-1:0]    chan_out
);
  localparam int SEG_LEN = NUM_CH / MASK_IN_W;

  logic              rst_n_int;
  mask_mode_e        mode;
  logic [NUM_CH-1:0] m0_all, m1_all;

  assign mode = mask_mode_e'(dual_mode);

  xmask_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar s = 0; s < MASK_IN_W; s++) begin : g_seg
    xmask_seg #(.SEG_LEN(SEG_LEN)) u_seg (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .load_i (mask_load),
      .mode_i (mode),
      .din_i  (mask_sin[s]),
      .m0_o   (m0_all[s*SEG_LEN +: SEG_LEN]),
      .m1_o   (m1_all[s*SEG_LEN +: SEG_LEN])
    );
  end

  xmask_gate #(.NUM_CH(NUM_CH)) u_gate (
    .chan_i (chan_in),
    .m0_i   (m0_all),
    .m1_i   (m1_all),
    .en0_i  (apply_en0),
    .en1_i  (apply_en1),
    .mode_i (mode),
    .off_i  (mask_off),
    .chan_o (chan_out)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n_int |=> (m0_all == '0 && m1_all == '0));
endmodule

// File: tb/xmask_unit_tb.sv
module xmask_unit_tb;
  localparam int NUM_CH    = 16;
  localparam int MASK_IN_W = 4;
  localparam int SEG_LEN   = NUM_CH / MASK_IN_W;
  localparam int CLK_P     = 10;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 dual_mode, mask_off, mask_load, apply_en0, apply_en1;
  logic [MASK_IN_W-1:0] mask_sin;
  logic [NUM_CH-1:0]    chan_in, chan_out;

  logic [NUM_CH-1:0] m0m, m1m;
  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  xmask_unit #(.NUM_CH(NUM_CH), .MASK_IN_W(MASK_IN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .mask_off(mask_off),
    .mask_load(mask_load), .mask_sin(mask_sin), .apply_en0(apply_en0),
    .apply_en1(apply_en1), .chan_in(chan_in), .chan_out(chan_out)
  );

  function automatic logic [NUM_CH-1:0] model_out(
    logic [NUM_CH-1:0] cin, logic [NUM_CH-1:0] a, logic [NUM_CH-1:0] b,
    logic e0, logic e1, logic dm, logic off);
    logic [NUM_CH-1:0] kill;
    kill = (e0 ? a : '0) | ((dm && e1) ? b : '0);
    return off ? cin : (cin & ~kill);
  endfunction

  task automatic chk(string tag, logic [NUM_CH-1:0] got, logic [NUM_CH-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_shift(logic dm, logic [MASK_IN_W-1:0] sin);
    logic [NUM_CH-1:0] o0, o1;
    o0 = m0m; o1 = m1m;
    for (int s = 0; s < MASK_IN_W; s++) begin
      m0m[s*SEG_LEN] = sin[s];
      if (dm) m1m[s*SEG_LEN] = o0[s*SEG_LEN+SEG_LEN-1];
      for (int i = 1; i < SEG_LEN; i++) begin
        m0m[s*SEG_LEN+i] = o0[s*SEG_LEN+i-1];
        if (dm) m1m[s*SEG_LEN+i] = o1[s*SEG_LEN+i-1];
      end
    end
  endtask

  // one cycle: drive at negedge, judge before posedge, update model at posedge
  task automatic step(logic ld, logic dm, logic off, logic e0, logic e1,
                      logic [MASK_IN_W-1:0] sin, logic [NUM_CH-1:0] cin, string tag);
    string t;
    @(negedge clk);
    mask_load = ld; dual_mode = dm; mask_off = off;
    apply_en0 = e0; apply_en1 = e1; mask_sin = sin; chan_in = cin;
    #1;
    if (tag != "") t = tag;
    else if (off) t = "R8";
    else if (ld)  t = "R9";
    else if (dm)  t = "R6";
    else          t = "R5";
    chk(t, chan_out, model_out(cin, m0m, m1m, e0, e1, dm, off));
    @(posedge clk);
    if (ld) model_shift(dm, sin);
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; dual_mode = 0; mask_off = 0; mask_load = 0;
    apply_en0 = 0; apply_en1 = 0; mask_sin = '0; chan_in = '0;
    m0m = '0; m1m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: after reset nothing is masked in either mode
    step(0, 0, 0, 1, 1, '0, '1, "R1");
    step(0, 1, 0, 1, 1, '0, '1, "R1");

    // R2: single mode, a 1 sent last on segment 0 lands on channel 0
    for (int k = 0; k < SEG_LEN; k++)
      step(1, 0, 0, 0, 0, (k == SEG_LEN-1) ? MASK_IN_W'(1) : '0, '1, "R9");
    step(0, 0, 0, 1, 0, '0, '1, "R2");
    chk("R2", chan_out, ~NUM_CH'(1));
    // R5: en1 ignored in single mode
    step(0, 0, 0, 0, 1, '0, '1, "R5");

    // R3: dual mode, a 1 sent first on segment 1 ends in second-mask of its last channel
    for (int k = 0; k < 2*SEG_LEN; k++)
      step(1, 1, 0, 0, 0, (k == 0) ? MASK_IN_W'(2) : '0, '1, "R9");
    step(0, 1, 0, 0, 1, '0, '1, "R3");
    chk("R3", chan_out, ~(NUM_CH'(1) << (2*SEG_LEN-1)));
    step(0, 1, 0, 1, 0, '0, '1, "R6");
    // R3: single-mode load must leave second-mask bits alone
    for (int k = 0; k < SEG_LEN; k++)
      step(1, 0, 0, 0, 0, '1, '1, "R9");
    step(0, 1, 0, 0, 1, '0, '1, "R3");
    chk("R3", chan_out, ~(NUM_CH'(1) << (2*SEG_LEN-1)));
    // R4: scan data toggling with load low changes nothing
    for (int k = 0; k < 6; k++)
      step(0, 1, 0, 1, 1, MASK_IN_W'($urandom), '1, "R4");
    // R8: mask off passes everything
    step(0, 1, 1, 1, 1, '0, '1, "R8");
    // R7: masked channels zero, others follow markers
    step(0, 1, 0, 1, 1, '0, 16'hA5C3, "R7");

    // random patterns: load, then unload, gating active throughout
    for (int p = 0; p < 60; p++) begin
      logic dm;
      dm = 1'($urandom);
      for (int k = 0; k < (dm ? 2*SEG_LEN : SEG_LEN); k++)
        step(1, dm, 1'($urandom_range(0, 7) == 0), 1'($urandom), 1'($urandom),
             MASK_IN_W'($urandom), NUM_CH'($urandom), "");
      for (int k = 0; k < 20; k++)
        step(0, dm, 1'($urandom_range(0, 7) == 0), 1'($urandom), 1'($urandom),
             MASK_IN_W'($urandom), NUM_CH'($urandom), "");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule